// File: doc/BRIEF.md
# Lockable Converter Control Word

This block holds the 16-bit configuration word of a sigma-delta converter front end and sits behind a simple write/read bus with an address decode. The word selects who drives the converter's power and conversion-start controls. It also carries the output shift, the output resolution, the data format, an interrupt-delay setting and an auto-stop-disable flag. Reads return the stored word, and every reserved bit reads as zero.

Two external lock inputs guard the word. While either lock is high, a bus write to the word is dropped silently. The top bit picks the control source. When it is 0, the software power-on and start bits drive the converter. When it is 1, an external acquisition sequencer's arm and trigger lines drive it. The chosen pair passes through a register stage, so changing the source never produces a glitch.

The block also resolves the shift, resolution and format codes into effective values. Invalid and reserved codes collapse to their safe defaults, so the datapath downstream sees only legal settings.

Top module: `cvt_ctrl_reg`

## Requirements
- R1: While reset is held and after it is released, the word reads 0x8001 (source 1, auto-stop-disable 1), and both converter control outputs are 0.
- R2: A write to address REG_ADDR (default 0x8) with both locks low stores the data into the writable bits 15, 13:8 and 2:0 on that clock edge. Reads of address 0x8 show the new value in the following cycle.
- R3: A write while lock_trig_en, lock_global or both are high leaves the word unchanged.
- R4: Bits 14 and 7:3 always read 0, whatever data is written.
- R5: With bit 15 = 0, cvt_pwr_up follows sw_pwr_on and cvt_conv_start follows sw_start, delayed by one clock edge. The outputs do not change between edges.
- R6: With bit 15 = 1, cvt_pwr_up follows seq_arm and cvt_conv_start follows seq_trig, delayed by one clock edge.
- R7: A write to any other address leaves the word unchanged, and a read of any other address returns 0.
- R8: eff_shift is derived from the shift field (bits 13:12) and the resolution field. It equals the shift code when the code is 1 and the resolution code is not 2. It also equals the shift code when the code is 2 and the resolution code is not 1. In every other case it is 0.
- R9: eff_res_bits is 12, 13 or 14 for resolution codes (bits 11:10) 0, 1 and 2, and 12 for code 3.
- R10: eff_offset_bin is 1 only when the format field (bits 9:8) is 1. Codes 0, 2 and 3 mean two's complement.
- R11: cfg_int_dly shows bits 2:1 and cfg_auto_stop_dis shows bit 0 of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Read data, 0 when address does not match |
| lock_trig_en | input | 1 | Lock: trigger enable active |
| lock_global | input | 1 | Lock: global configuration lock |
| sw_pwr_on | input | 1 | Software power request |
| sw_start | input | 1 | Software conversion start request |
| seq_arm | input | 1 | Sequencer arm (power) request |
| seq_trig | input | 1 | Sequencer trigger (start) request |
| cvt_pwr_up | output | 1 | Registered converter power control |
| cvt_conv_start | output | 1 | Registered conversion start control |
| cfg_int_dly | output | 2 | Interrupt-delay setting |
| cfg_auto_stop_dis | output | 1 | Auto-stop-disable flag |
| eff_shift | output | 2 | Effective output shift |
| eff_res_bits | output | 4 | Effective output resolution in bits |
| eff_offset_bin | output | 1 | 1 = offset binary output format |

## Verification
The field sweep writes all 1024 combinations of the writable fields, with varying junk in the reserved bits. It checks the read-back, which shows that the write mask and the reserved zeroing are right. It also checks every effective-value decode, and so separates the invalid shift-and-resolution pairs from the legal ones. The lock patterns apply each lock alone and both together. Foreign-address writes and reads separate address decode faults from lock faults. The routing pass drives all 16 combinations of the four request inputs under each source. It samples both just after the drive and one edge later, which distinguishes a wrong source, swapped lines and a missing register stage.

// File: rtl/cvt_ctrl_pkg.sv
package cvt_ctrl_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned RES_BASE = 12;
  localparam logic [WORD_W-1:0] RESET_WORD = 16'h8001;
  localparam logic [WORD_W-1:0] WR_MASK    = 16'hBF07;

  typedef struct packed {
    logic       src_sel;
    logic       rsvd_hi;
    logic [1:0] msb_shift;
    logic [1:0] res_code;
    logic [1:0] fmt_code;
    logic [4:0] rsvd_lo;
    logic [1:0] int_dly;
    logic       auto_stop_dis;
  } ctrl_word_t;
endpackage

// File: rtl/cvt_rst_sync.sv
module cvt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign srst_n = stg_q[STAGES-1];
endmodule

// File: rtl/cvt_ctrl_store.sv
module cvt_ctrl_store
  import cvt_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              lock_a,
  input  logic              lock_b,
  output logic [WORD_W-1:0] word_q
);
  logic              hit;
  logic              locked;
  logic              upd_en;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    hit    = wr_en && (addr == REG_ADDR);
    locked = lock_a || lock_b;
    upd_en = hit && !locked;
    word_d = wdata & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= RESET_WORD;
    else if (upd_en) word_q <= word_d;
  end

  // R3: a write attempt under either lock leaves the word alone
  p_lock_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (lock_a || lock_b)) |=> $stable(word_q));

  // R7: anything other than a strobe to our address leaves the word alone
  p_foreign_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == REG_ADDR)) |=> $stable(word_q));

  // R4: reserved positions never hold a 1
  p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q & ~WR_MASK) == '0);
endmodule

// File: rtl/cvt_ctrl_decode.sv
module cvt_ctrl_decode
  import cvt_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] shift_code,
  input  logic [1:0] res_code,
  input  logic [1:0] fmt_code,
  output logic [1:0] eff_shift,
  output logic [3:0] eff_res_bits,
  output logic       eff_offset_bin
);
  always_comb begin
    unique case (shift_code)
      2'd1:    eff_shift = (res_code == 2'd2) ? 2'd0 : 2'd1;
      2'd2:    eff_shift = (res_code == 2'd1) ? 2'd0 : 2'd2;
      default: eff_shift = 2'd0;
    endcase
    if (res_code == 2'd3) eff_res_bits = 4'(RES_BASE);
    else                  eff_res_bits = 4'(RES_BASE) + {2'b00, res_code};
    eff_offset_bin = (fmt_code == 2'd1);
  end

  // R8: a 13-bit result is never shifted by 2, a 14-bit one never by 1
  p_shift_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !((res_code == 2'd2 && eff_shift == 2'd1) || (res_code == 2'd1 && eff_shift == 2'd2)));

  // R9: resolution stays within the supported range
  p_res_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_res_bits >= 4'd12) && (eff_res_bits <= 4'd14));

  // R10: offset binary only from its own code
  p_fmt_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eff_offset_bin |-> (fmt_code == 2'd1));
endmodule

// File: rtl/cvt_src_mux.sv
module cvt_src_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic sw_pwr,
  input  logic sw_go,
  input  logic seq_arm,
  input  logic seq_trig,
  output logic pwr_q,
  output logic go_q
);
  logic pwr_d;
  logic go_d;

  always_comb begin
    pwr_d = src_sel ? seq_arm  : sw_pwr;
    go_d  = src_sel ? seq_trig : sw_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      pwr_q <= pwr_d;
      go_q  <= go_d;
    end
  end

  // R5: software bits steer the converter one edge later
  p_sw_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !src_sel |=> (pwr_q == $past(sw_pwr)) && (go_q == $past(sw_go)));

  // R6: sequencer lines steer the converter one edge later
  p_seq_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel |=> (pwr_q == $past(seq_arm)) && (go_q == $past(seq_trig)));
endmodule

// File: rtl/cvt_ctrl_reg.sv
module cvt_ctrl_reg
  import cvt_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              lock_trig_en,
  input  logic              lock_global,
  input  logic              sw_pwr_on,
  input  logic              sw_start,
  input  logic              seq_arm,
  input  logic              seq_trig,
  output logic              cvt_pwr_up,
  output logic              cvt_conv_start,
  output logic [1:0]        cfg_int_dly,
  output logic              cfg_auto_stop_dis,
  output logic [1:0]        eff_shift,
  output logic [3:0]        eff_res_bits,
  output logic              eff_offset_bin
);
  logic              srst_n;
  logic [WORD_W-1:0] word_q;
  ctrl_word_t        cw;

  cvt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cvt_ctrl_store #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_store (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .lock_a (lock_trig_en),
    .lock_b (lock_global),
    .word_q (word_q)
  );

  assign cw = ctrl_word_t'(word_q);

  cvt_ctrl_decode u_dec (
    .clk            (clk),
    .rst_n          (srst_n),
    .shift_code     (cw.msb_shift),
    .res_code       (cw.res_code),
    .fmt_code       (cw.fmt_code),
    .eff_shift      (eff_shift),
    .eff_res_bits   (eff_res_bits),
    .eff_offset_bin (eff_offset_bin)
  );

  cvt_src_mux u_mux (
    .clk      (clk),
    .rst_n    (srst_n),
    .src_sel  (cw.src_sel),
    .sw_pwr   (sw_pwr_on),
    .sw_go    (sw_start),
    .seq_arm  (seq_arm),
    .seq_trig (seq_trig),
    .pwr_q    (cvt_pwr_up),
    .go_q     (cvt_conv_start)
  );

  always_comb begin
    bus_rdata         = (bus_addr == REG_ADDR) ? word_q : '0;
    cfg_int_dly       = cw.int_dly;
    cfg_auto_stop_dis = cw.auto_stop_dis;
  end

  // R7: a foreign address reads as zero
  p_rdata_decode_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_addr != REG_ADDR) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_cvt_ctrl_reg.sv
`timescale 1ns/1ps
module sim_cvt_ctrl_reg;
  localparam logic [3:0] RA = 4'h8;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr;
  logic [3:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic lock_trig_en, lock_global;
  logic sw_pwr_on, sw_start, seq_arm, seq_trig;
  logic cvt_pwr_up, cvt_conv_start;
  logic [1:0] cfg_int_dly;
  logic cfg_auto_stop_dis;
  logic [1:0] eff_shift;
  logic [3:0] eff_res_bits;
  logic eff_offset_bin;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cvt_ctrl_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lock_trig_en(lock_trig_en), .lock_global(lock_global),
    .sw_pwr_on(sw_pwr_on), .sw_start(sw_start),
    .seq_arm(seq_arm), .seq_trig(seq_trig),
    .cvt_pwr_up(cvt_pwr_up), .cvt_conv_start(cvt_conv_start),
    .cfg_int_dly(cfg_int_dly), .cfg_auto_stop_dis(cfg_auto_stop_dis),
    .eff_shift(eff_shift), .eff_res_bits(eff_res_bits),
    .eff_offset_bin(eff_offset_bin)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = RA;
    #0.5;
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = RA; bus_wdata = '0;
    lock_trig_en = 1'b0; lock_global = 1'b0;
    sw_pwr_on = 1'b0; sw_start = 1'b0; seq_arm = 1'b0; seq_trig = 1'b0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk("R1 reset word", bus_rdata, 16'h8001);
    chk("R1 reset outputs", {14'd0, cvt_pwr_up, cvt_conv_start}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 word after release", bus_rdata, 16'h8001);
    chk("R1 outputs after release", {14'd0, cvt_pwr_up, cvt_conv_start}, 16'h0);
    chk("R11 reset auto-stop", {15'd0, cfg_auto_stop_dis}, 16'h1);

    // R2, R4, R8, R9, R10, R11: sweep of every writable field combination
    for (int i = 0; i < 1024; i++) begin
      logic [1:0] sh, rs, fm, dl;
      logic src, asd;
      logic [4:0] junk;
      logic [1:0] xs;
      logic [3:0] xr;
      src = i[9]; sh = i[8:7]; rs = i[6:5]; fm = i[4:3]; dl = i[2:1]; asd = i[0];
      junk = 5'((i * 7) + 3);
      wr(RA, {src, i[3] ^ i[6], sh, rs, fm, junk, dl, asd});
      chk("R2/R4 readback", bus_rdata, {src, 1'b0, sh, rs, fm, 5'b0, dl, asd});
      if (sh == 2'd1 && rs != 2'd2)      xs = 2'd1;
      else if (sh == 2'd2 && rs != 2'd1) xs = 2'd2;
      else                               xs = 2'd0;
      chk("R8 eff shift", {14'd0, eff_shift}, {14'd0, xs});
      xr = (rs == 2'd3) ? 4'd12 : 4'd12 + {2'd0, rs};
      chk("R9 eff res", {12'd0, eff_res_bits}, {12'd0, xr});
      chk("R10 offset bin", {15'd0, eff_offset_bin}, {15'd0, fm == 2'd1});
      chk("R11 int dly/auto stop", {13'd0, cfg_int_dly, cfg_auto_stop_dis}, {13'd0, dl, asd});
    end

    // R4: all-ones write
    wr(RA, 16'hFFFF);
    chk("R4 reserved clear", bus_rdata, 16'hBF07);

    // R3: lock combinations
    wr(RA, 16'h0000);
    for (int l = 1; l < 4; l++) begin
      lock_trig_en = l[0]; lock_global = l[1];
      wr(RA, 16'hBF07);
      chk("R3 locked write dropped", bus_rdata, 16'h0000);
    end
    lock_trig_en = 1'b0; lock_global = 1'b0;
    wr(RA, 16'h2506);
    chk("R2 write after unlock", bus_rdata, 16'h2506);

    // R7: foreign addresses
    for (int a = 0; a < 16; a++) begin
      if (a != 8) begin
        wr(4'(a), 16'h9A05);
        bus_addr = 4'(a); #0.5;
        chk("R7 foreign read zero", bus_rdata, 16'h0000);
        bus_addr = RA; #0.5;
        chk("R7 word kept", bus_rdata, 16'h2506);
      end
    end

    // R5, R6: source routing, all request patterns
    for (int s = 0; s < 2; s++) begin
      wr(RA, s[0] ? 16'h8000 : 16'h0000);
      for (int p = 0; p < 16; p++) begin
        logic [1:0] prev, expv;
        @(negedge clk);
        prev = {cvt_pwr_up, cvt_conv_start};
        sw_pwr_on = p[0]; sw_start = p[1]; seq_arm = p[2]; seq_trig = p[3];
        #0.5;
        chk(s[0] ? "R6 no change before edge" : "R5 no change before edge",
            {14'd0, cvt_pwr_up, cvt_conv_start}, {14'd0, prev});
        expv = s[0] ? {p[2], p[3]} : {p[0], p[1]};
        @(negedge clk); #0.5;
        chk(s[0] ? "R6 sequencer route" : "R5 software route",
            {14'd0, cvt_pwr_up, cvt_conv_start}, {14'd0, expv});
      end
    end

    done = 1'b1;
    report();
  end
endmodule